// File: doc/BRIEF.md
# Length-prefixed CRC-32 packet framer

This block moves single packets into and out of a byte-addressed shared memory area. Its framing engine takes a packet as a valid/ready byte stream. It copies every byte unchanged to the area, starting four bytes above the base address. When the selected version is 3 it adds a four-byte CRC-32 after the last payload byte. It then fills the first four bytes of the area with the payload length, most significant byte first. Its deframing engine reads that length, checks it against the room the area offers, and streams the payload back out. In version 3 it then reads the trailer and reports whether it matches.

Both engines share one memory port and one control sequencer, so only one packet operation runs at a time. A start pulse takes its own snapshot of the base address and the version. A done pulse ends each operation. The CRC starts from all ones and takes each byte least-significant bit first through the reflected polynomial 0xEDB88320. The result is inverted. The CRC advances by one byte per clock as bytes are accepted.

Top module: `lenCrcTop`

## Requirements
- R1: After a framing run, the four bytes at base..base+3 hold the number of payload bytes, stored big-endian (base holds bits 31:24).
- R2: Payload byte i is written unchanged to base+4+i, with no escaping.
- R3: With version 3, the CRC-32 of the payload is written big-endian at base+4+n..base+4+n+3, where n is the payload length. The CRC starts at 0xFFFFFFFF, uses reflected polynomial 0xEDB88320 and is inverted at the end. The nine ASCII bytes "123456789" give 0xCBF43926.
- R4: With any version other than 3, no trailer is written: the byte at base+4+n keeps its earlier value.
- R5: txDone is high for exactly one cycle. It comes in the cycle after the memory port accepts the last header write. No memory write follows it.
- R6: A memory request keeps its address, write data and direction until memGnt is high at a clock edge. Read data is taken from memRdata in the cycle after the grant.
- R7: A deframing run presents exactly as many bytes as the stored length, in address order, and marks the final byte with outLast. outData and outLast hold while outValid is high and outReady is low. rxLen reports the stored length.
- R8: A stored length of zero, or one larger than the area size minus 4 (minus 8 in version 3), sets rxLenErr at rxDone. In that case no payload byte is presented and no trailer is read.
- R9: With version 3, rxCrcErr is 0 at rxDone when the stored trailer equals the CRC of the bytes read, and 1 otherwise. With other versions, rxCrcErr stays 0 whatever follows the payload.
- R10: During and after reset the block is idle: no memory request, inReady, outValid, txDone, rxDone, rxLenErr or rxCrcErr.
- R11: Start pulses that arrive while an operation runs are ignored. When txStart and rxStart arrive together at idle, the framing run is taken and the read request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| baseAddr | input | AW | First byte of the area, sampled at a start pulse |
| version | input | 2 | Framing version, sampled at a start pulse; 3 adds the trailer |
| txStart | input | 1 | Start a framing run |
| inValid | input | 1 | Payload byte offered |
| inReady | output | 1 | Framer takes the offered byte |
| inData | input | 8 | Payload byte in |
| inLast | input | 1 | Offered byte is the final one |
| txDone | output | 1 | Framing finished (one cycle) |
| rxStart | input | 1 | Start a deframing run |
| outValid | output | 1 | Payload byte presented |
| outReady | input | 1 | Consumer takes the presented byte |
| outData | output | 8 | Payload byte out |
| outLast | output | 1 | Presented byte is the final one |
| rxDone | output | 1 | Deframing finished (one cycle) |
| rxLen | output | 32 | Length read from the header |
| rxLenErr | output | 1 | Length rejected |
| rxCrcErr | output | 1 | Trailer mismatch (version 3) |
| memReq | output | 1 | Memory access requested |
| memWe | output | 1 | Access is a write |
| memGnt | input | 1 | Memory accepts the access this cycle |
| memAddr | output | AW | Byte address |
| memWdata | output | 8 | Write byte |
| memRdata | input | 8 | Read byte, valid the cycle after a read grant |

## Verification
A payload byte goes to memory at the first granted edge after the framer accepts it. txDone rises one cycle after the final header grant. The bench waits for it and then counts writes for three more cycles. On reads, each granted byte is captured one cycle later and shown on outData in the cycle after that. The bench samples each handshake half a cycle before the edge that completes it. rxLenErr, rxCrcErr and rxLen are read in the cycle where rxDone is high, since the last header or trailer byte is judged one cycle before that point.

// File: rtl/lenCrcPkg.sv
package lenCrcPkg;

  typedef enum logic [3:0] {
    S_IDLE, T_IN, T_PAY, T_TLR, T_HDR, T_DONE,
    R_HDR_RD, R_HDR_CAP, R_CHECK, R_PAY_RD, R_PAY_CAP,
    R_OUT, R_TLR_RD, R_TLR_CAP, R_CMP, R_DONE
  } engState_t;

  typedef enum logic [1:0] {AS_HDR, AS_PAY, AS_TLR} addrSel_t;

  typedef struct packed {
    logic     start;
    logic     takeIn;
    logic     takeMem;
    logic     incCnt;
    logic     incIdx;
    logic     shiftLen;
    logic     shiftTlr;
    logic     flagLen;
    logic     flagCrc;
    addrSel_t addrSel;
  } dpStrobe_t;

  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED     = 32'hFFFFFFFF;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] beByte(input logic [31:0] w, input logic [1:0] i);
    case (i)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

endpackage

// File: rtl/lenCrcDatapath.sv
module lenCrcDatapath
  import lenCrcPkg::*;
#(
  parameter int AW         = 8,
  parameter int AREA_BYTES = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       st,
  input  logic [AW-1:0]   baseAddr,
  input  logic [1:0]      version,
  input  logic [7:0]      inData,
  input  logic [7:0]      memRdata,
  output logic [AW-1:0]   memAddr,
  output logic [7:0]      memWdata,
  output logic [7:0]      outData,
  output logic            idxLast,
  output logic            lenBad,
  output logic            payLast,
  output logic            trailerOn,
  output logic            rxLenErr,
  output logic            rxCrcErr,
  output logic [31:0]     rxLen
);

  localparam int HDR_BYTES = 4;
  localparam int TLR_BYTES = 4;
  localparam logic [31:0] MAX_PAY_PLAIN = 32'(AREA_BYTES - HDR_BYTES);
  localparam logic [31:0] MAX_PAY_CRC   = 32'(AREA_BYTES - HDR_BYTES - TLR_BYTES);

  logic [AW-1:0] baseQ;
  logic          trailerQ;
  logic [31:0]   crcQ, cntQ, lenQ, tlrQ;
  logic [1:0]    idxQ;
  logic [7:0]    dataQ;
  logic          lenErrQ, crcErrQ;
  logic [31:0]   crcFinal, maxPay;
  logic [AW-1:0] payAddr;

  assign crcFinal = ~crcQ;
  assign maxPay   = trailerQ ? MAX_PAY_CRC : MAX_PAY_PLAIN;
  assign payAddr  = baseQ + AW'(HDR_BYTES) + cntQ[AW-1:0];

  always_comb begin
    case (st.addrSel)
      AS_HDR: begin
        memAddr  = baseQ + AW'(idxQ);
        memWdata = beByte(cntQ, idxQ);
      end
      AS_PAY: begin
        memAddr  = payAddr;
        memWdata = dataQ;
      end
      default: begin
        memAddr  = payAddr + AW'(idxQ);
        memWdata = beByte(crcFinal, idxQ);
      end
    endcase
  end

  assign outData   = dataQ;
  assign idxLast   = (idxQ == 2'd3);
  assign lenBad    = (lenQ == 32'd0) || (lenQ > maxPay);
  assign payLast   = (cntQ == lenQ - 32'd1);
  assign trailerOn = trailerQ;
  assign rxLenErr  = lenErrQ;
  assign rxCrcErr  = crcErrQ;
  assign rxLen     = lenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ    <= '0;
      trailerQ <= 1'b0;
      crcQ     <= CRC_SEED;
      cntQ     <= '0;
      idxQ     <= '0;
      lenQ     <= '0;
      tlrQ     <= '0;
      dataQ    <= '0;
      lenErrQ  <= 1'b0;
      crcErrQ  <= 1'b0;
    end else if (st.start) begin
      baseQ    <= baseAddr;
      trailerQ <= (version == 2'd3);
      crcQ     <= CRC_SEED;
      cntQ     <= '0;
      idxQ     <= '0;
      lenQ     <= '0;
      tlrQ     <= '0;
      lenErrQ  <= 1'b0;
      crcErrQ  <= 1'b0;
    end else begin
      if (st.takeIn) begin
        crcQ  <= crcByte(crcQ, inData);
        dataQ <= inData;
      end
      if (st.takeMem) begin
        crcQ  <= crcByte(crcQ, memRdata);
        dataQ <= memRdata;
      end
      if (st.incCnt)   cntQ    <= cntQ + 32'd1;
      if (st.incIdx)   idxQ    <= idxQ + 2'd1;
      if (st.shiftLen) lenQ    <= {lenQ[23:0], memRdata};
      if (st.shiftTlr) tlrQ    <= {tlrQ[23:0], memRdata};
      if (st.flagLen)  lenErrQ <= 1'b1;
      if (st.flagCrc)  crcErrQ <= (tlrQ != crcFinal);
    end
  end

  p_crc_only_v3_r9: assert property (@(posedge clk) disable iff (!rstN)
    crcErrQ |-> trailerQ);
  p_len_err_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    lenErrQ |-> !crcErrQ);

endmodule

// File: rtl/lenCrcControl.sv
module lenCrcControl
  import lenCrcPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txStart,
  input  logic      rxStart,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      memGnt,
  input  logic      outReady,
  input  logic      idxLast,
  input  logic      lenBad,
  input  logic      payLast,
  input  logic      trailerOn,
  output dpStrobe_t st,
  output logic      inReady,
  output logic      memReq,
  output logic      memWe,
  output logic      outValid,
  output logic      outLast,
  output logic      txDone,
  output logic      rxDone,
  output logic      busy
);

  engState_t state, nxt;
  logic      lastSeenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      lastSeenQ <= 1'b0;
    end else begin
      state <= nxt;
      if (state == T_IN && inValid) lastSeenQ <= inLast;
    end
  end

  always_comb begin
    nxt        = state;
    st         = '0;
    st.addrSel = AS_HDR;
    inReady    = 1'b0;
    memReq     = 1'b0;
    memWe      = 1'b0;
    outValid   = 1'b0;
    txDone     = 1'b0;
    rxDone     = 1'b0;
    case (state)
      S_IDLE: begin
        if (txStart) begin
          st.start = 1'b1;
          nxt      = T_IN;
        end else if (rxStart) begin
          st.start = 1'b1;
          nxt      = R_HDR_RD;
        end
      end
      T_IN: begin
        inReady = 1'b1;
        if (inValid) begin
          st.takeIn = 1'b1;
          nxt       = T_PAY;
        end
      end
      T_PAY: begin
        memReq = 1'b1; memWe = 1'b1; st.addrSel = AS_PAY;
        if (memGnt) begin
          st.incCnt = 1'b1;
          if (lastSeenQ) nxt = trailerOn ? T_TLR : T_HDR;
          else           nxt = T_IN;
        end
      end
      T_TLR: begin
        memReq = 1'b1; memWe = 1'b1; st.addrSel = AS_TLR;
        if (memGnt) begin
          st.incIdx = 1'b1;
          if (idxLast) nxt = T_HDR;
        end
      end
      T_HDR: begin
        memReq = 1'b1; memWe = 1'b1; st.addrSel = AS_HDR;
        if (memGnt) begin
          st.incIdx = 1'b1;
          if (idxLast) nxt = T_DONE;
        end
      end
      T_DONE: begin
        txDone = 1'b1;
        nxt    = S_IDLE;
      end
      R_HDR_RD: begin
        memReq = 1'b1; st.addrSel = AS_HDR;
        if (memGnt) nxt = R_HDR_CAP;
      end
      R_HDR_CAP: begin
        st.shiftLen = 1'b1;
        st.incIdx   = 1'b1;
        nxt         = idxLast ? R_CHECK : R_HDR_RD;
      end
      R_CHECK: begin
        if (lenBad) begin
          st.flagLen = 1'b1;
          nxt        = R_DONE;
        end else begin
          nxt = R_PAY_RD;
        end
      end
      R_PAY_RD: begin
        memReq = 1'b1; st.addrSel = AS_PAY;
        if (memGnt) nxt = R_PAY_CAP;
      end
      R_PAY_CAP: begin
        st.takeMem = 1'b1;
        nxt        = R_OUT;
      end
      R_OUT: begin
        outValid = 1'b1;
        if (outReady) begin
          st.incCnt = 1'b1;
          if (payLast) nxt = trailerOn ? R_TLR_RD : R_DONE;
          else         nxt = R_PAY_RD;
        end
      end
      R_TLR_RD: begin
        memReq = 1'b1; st.addrSel = AS_TLR;
        if (memGnt) nxt = R_TLR_CAP;
      end
      R_TLR_CAP: begin
        st.shiftTlr = 1'b1;
        st.incIdx   = 1'b1;
        nxt         = idxLast ? R_CMP : R_TLR_RD;
      end
      R_CMP: begin
        st.flagCrc = 1'b1;
        nxt        = R_DONE;
      end
      R_DONE: begin
        rxDone = 1'b1;
        nxt    = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign outLast = (state == R_OUT) && payLast;
  assign busy    = (state != S_IDLE);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && (memWe == $past(memWe)));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txDone || rxDone) |=> !(txDone || rxDone));

endmodule

// File: rtl/lenCrcTop.sv
module lenCrcTop
  import lenCrcPkg::*;
#(
  parameter int AW         = 8,
  parameter int AREA_BYTES = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] baseAddr,
  input  logic [1:0]    version,
  input  logic          txStart,
  input  logic          inValid,
  output logic          inReady,
  input  logic [7:0]    inData,
  input  logic          inLast,
  output logic          txDone,
  input  logic          rxStart,
  output logic          outValid,
  input  logic          outReady,
  output logic [7:0]    outData,
  output logic          outLast,
  output logic          rxDone,
  output logic [31:0]   rxLen,
  output logic          rxLenErr,
  output logic          rxCrcErr,
  output logic          memReq,
  output logic          memWe,
  input  logic          memGnt,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  input  logic [7:0]    memRdata
);

  dpStrobe_t st;
  logic idxLast, lenBad, payLast, trailerOn, busy;

  lenCrcControl u_ctrl (
    .clk(clk), .rstN(rstN), .txStart(txStart), .rxStart(rxStart),
    .inValid(inValid), .inLast(inLast), .memGnt(memGnt), .outReady(outReady),
    .idxLast(idxLast), .lenBad(lenBad), .payLast(payLast), .trailerOn(trailerOn),
    .st(st), .inReady(inReady), .memReq(memReq), .memWe(memWe),
    .outValid(outValid), .outLast(outLast), .txDone(txDone), .rxDone(rxDone),
    .busy(busy)
  );

  lenCrcDatapath #(.AW(AW), .AREA_BYTES(AREA_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .baseAddr(baseAddr), .version(version),
    .inData(inData), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .outData(outData), .idxLast(idxLast), .lenBad(lenBad), .payLast(payLast),
    .trailerOn(trailerOn), .rxLenErr(rxLenErr), .rxCrcErr(rxCrcErr), .rxLen(rxLen)
  );

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWdata));
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));
  p_len_err_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxLenErr |-> !outValid);
  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> !memReq);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !outValid && !inReady);

endmodule

// File: tb/sim_lenCrcTop.sv
module sim_lenCrcTop;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 8;
  localparam int AREA       = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [AW-1:0] baseAddr = '0;
  logic [1:0]    version = 2'd1;
  logic txStart = 1'b0, rxStart = 1'b0, inValid = 1'b0, inLast = 1'b0;
  logic [7:0] inData = 8'h0;
  logic inReady, txDone, outValid, outLast, rxDone, rxLenErr, rxCrcErr, memReq, memWe;
  logic outReady, memGnt;
  logic [7:0] outData, memWdata;
  logic [7:0] memRdata = 8'h0;
  logic [AW-1:0] memAddr;
  logic [31:0] rxLen;

  logic slowMode = 1'b0;
  logic [1:0] phase = 2'd0;
  assign memGnt   = !slowMode || (phase != 2'd0);
  assign outReady = !slowMode || (phase != 2'd2);

  logic [7:0] mem [0:255];
  logic fillReq = 1'b0, tbWe = 1'b0;
  logic [7:0] tbAddr = 8'h0, tbData = 8'h0;
  int txDoneCnt = 0, rxDoneCnt = 0, wrCount = 0;
  int nErr = 0, nChk = 0;
  bit wdHit = 1'b0;

  always @(posedge clk) begin
    phase <= phase + 2'd1;
    if (fillReq) begin
      for (int a = 0; a < 256; a++) mem[a] <= 8'hA5;
    end else if (tbWe) begin
      mem[tbAddr] <= tbData;
    end
    if (memReq && memGnt) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        wrCount <= wrCount + 1;
      end else begin
        memRdata <= mem[memAddr];
      end
    end
    if (txDone) txDoneCnt <= txDoneCnt + 1;
    if (rxDone) rxDoneCnt <= rxDoneCnt + 1;
  end

  lenCrcTop #(.AW(AW), .AREA_BYTES(AREA)) u0 (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .version(version),
    .txStart(txStart), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .txDone(txDone), .rxStart(rxStart), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast), .rxDone(rxDone),
    .rxLen(rxLen), .rxLenErr(rxLenErr), .rxCrcErr(rxCrcErr), .memReq(memReq),
    .memWe(memWe), .memGnt(memGnt), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  function automatic logic [7:0] payByte(int seed, int i);
    if (seed == 0) return 8'(8'h31 + i);
    return 8'(seed * 13 + i * 29 + 7);
  endfunction

  function automatic logic [31:0] refCrc(int seed, int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, payByte(seed, i)};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fillMem();
    fillReq = 1'b1;
    @(negedge clk);
    fillReq = 1'b0;
  endtask

  task automatic tbWr(input int a, input logic [7:0] d);
    tbWe = 1'b1; tbAddr = 8'(a); tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic putHdr(input int b, input logic [31:0] v);
    for (int i = 0; i < 4; i++) tbWr(b + i, v[31 - 8 * i -: 8]);
  endtask

  // poke: 0 none, 1 rxStart mid-frame, 2 rxStart together with txStart
  task automatic frameTx(input int b, input int ver, input int len, input int seed, input int poke);
    int t, wr0, rx0;
    rx0 = rxDoneCnt;
    baseAddr = AW'(b); version = 2'(ver);
    txStart = 1'b1; rxStart = (poke == 2);
    @(negedge clk);
    txStart = 1'b0; rxStart = 1'b0;
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1; inData = payByte(seed, i); inLast = (i == len - 1);
      rxStart = (poke == 1) && (i == 1);
      t = 0;
      while (!inReady && t < 500) begin @(negedge clk); t++; end
      @(negedge clk);
      rxStart = 1'b0;
    end
    inValid = 1'b0; inLast = 1'b0;
    t = 0;
    while (!txDone && t < 500) begin @(negedge clk); t++; end
    chk("R5 txDone after last write", 32'(txDone), 32'd1);
    wr0 = wrCount;
    @(negedge clk);
    chk("R5 txDone one cycle", 32'(txDone), 32'd0);
    repeat (2) @(negedge clk);
    chk("R5 no write after txDone", 32'(wrCount), 32'(wr0));
    if (poke != 0) chk("R11 rxStart ignored", 32'(rxDoneCnt), 32'(rx0));
  endtask

  task automatic checkFrame(input int b, input int ver, input int len, input int seed);
    chk("R1 length header", {mem[b], mem[b + 1], mem[b + 2], mem[b + 3]}, 32'(len));
    for (int j = 0; j < len; j++) chk("R2 payload byte", 32'(mem[b + 4 + j]), 32'(payByte(seed, j)));
    if (ver == 3)
      chk("R3 crc trailer", {mem[b + 4 + len], mem[b + 5 + len], mem[b + 6 + len], mem[b + 7 + len]},
          refCrc(seed, len));
    else
      chk("R4 no trailer written", 32'(mem[b + 4 + len]), 32'hA5);
  endtask

  task automatic deframeRx(input int b, input int ver, input int len, input int seed,
                           input bit expLenErr, input bit expCrcErr, input bit poke);
    int t, got, tx0, wr0;
    tx0 = txDoneCnt; wr0 = wrCount;
    baseAddr = AW'(b); version = 2'(ver);
    rxStart = 1'b1;
    @(negedge clk);
    rxStart = 1'b0;
    got = 0; t = 0;
    while (!rxDone && t < 2000) begin
      if (outValid && outReady) begin
        if (got < len) chk("R7 payload out", 32'(outData), 32'(payByte(seed, got)));
        chk("R7 outLast", 32'(outLast), 32'(got == len - 1));
        got++;
      end
      txStart = poke && (t == 2);
      @(negedge clk);
      t++;
    end
    txStart = 1'b0;
    chk("R7 rxDone seen", 32'(rxDone), 32'd1);
    if (expLenErr) chk("R8 no bytes on bad length", 32'(got), 32'd0);
    else           chk("R7 byte count", 32'(got), 32'(len));
    chk("R8 length error flag", 32'(rxLenErr), 32'(expLenErr));
    chk("R9 crc error flag", 32'(rxCrcErr), 32'(expCrcErr));
    if (!expLenErr) chk("R7 rxLen", rxLen, 32'(len));
    @(negedge clk);
    if (poke) begin
      chk("R11 txStart ignored", 32'(txDoneCnt), 32'(tx0));
      chk("R11 no writes during read", 32'(wrCount), 32'(wr0));
    end
  endtask

  task automatic runAll();
    int b;
    repeat (3) @(negedge clk);
    chk("R10 reset memReq", 32'(memReq), 32'd0);
    chk("R10 reset inReady", 32'(inReady), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 idle outValid", 32'(outValid), 32'd0);
    chk("R10 idle done", 32'({txDone, rxDone}), 32'd0);
    chk("R10 idle flags", 32'({rxLenErr, rxCrcErr}), 32'd0);
    chk("R10 idle memReq", 32'(memReq), 32'd0);

    // R3 check string
    chk("R3 reference crc", refCrc(0, 9), 32'hCBF43926);
    fillMem();
    frameTx(16, 3, 9, 0, 0);
    checkFrame(16, 3, 9, 0);
    chk("R3 check string trailer", {mem[29], mem[30], mem[31], mem[32]}, 32'hCBF43926);
    deframeRx(16, 3, 9, 0, 1'b0, 1'b0, 1'b0);

    // sweep: every version, every accepted length, two port timings
    for (int gm = 0; gm < 2; gm++) begin
      slowMode = gm[0];
      for (int ver = 1; ver <= 3; ver++) begin
        for (int len = 1; len <= ((ver == 3) ? AREA - 8 : AREA - 4); len++) begin
          b = (len % 2 == 0) ? 16 : 96;
          fillMem();
          frameTx(b, ver, len, len + ver, 0);
          checkFrame(b, ver, len, len + ver);
          deframeRx(b, ver, len, len + ver, 1'b0, 1'b0, 1'b0);
        end
      end
    end
    slowMode = 1'b0;

    // R8 rejected lengths
    fillMem();
    putHdr(16, 32'd0);
    deframeRx(16, 1, 0, 1, 1'b1, 1'b0, 1'b0);
    putHdr(16, 32'(AREA - 3));
    deframeRx(16, 1, 0, 1, 1'b1, 1'b0, 1'b0);
    putHdr(16, 32'(AREA - 7));
    deframeRx(16, 3, 0, 1, 1'b1, 1'b0, 1'b0);
    putHdr(16, 32'(AREA - 4));
    deframeRx(16, 3, 0, 1, 1'b1, 1'b0, 1'b0);
    putHdr(16, 32'h0100_0001);
    deframeRx(16, 2, 0, 1, 1'b1, 1'b0, 1'b0);

    // R9 corrupted trailer in version 3
    fillMem();
    frameTx(96, 3, 10, 5, 0);
    tbWr(96 + 4 + 10 + 3, mem[96 + 4 + 10 + 3] ^ 8'h01);
    deframeRx(96, 3, 10, 5, 1'b0, 1'b1, 1'b0);
    // R9 version 2 ignores garbage after payload
    fillMem();
    frameTx(96, 2, 10, 5, 0);
    for (int i = 0; i < 4; i++) tbWr(96 + 14 + i, 8'(8'h3C + i));
    deframeRx(96, 2, 10, 5, 1'b0, 1'b0, 1'b0);

    // R11 starts while busy, and simultaneous starts at idle
    fillMem();
    frameTx(16, 1, 5, 3, 1);
    checkFrame(16, 1, 5, 3);
    deframeRx(16, 1, 5, 3, 1'b0, 1'b0, 1'b1);
    fillMem();
    frameTx(16, 2, 4, 9, 2);
    checkFrame(16, 2, 4, 9);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (190000) @(posedge clk);
        wdHit = 1'b1;
      end
    join_any
    disable fork;
    if (wdHit) begin
      nChk++;
      nErr++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule